// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix-Vector Array

This block is a grid of ROWS x COLS multiply-accumulate cells (3 x 3 by default) that computes a signed matrix-vector product O = W x I. It serves fully connected layers and convolutions lowered to matrix multiplication. Column c carries input channel c and row k produces output channel k. Cell (k, c) holds the weight W[k][c]. An activation enters at the top of its column and moves down one cell per cycle, so every row uses it. The partial sum of row k moves one cell right per cycle and leaves at the right edge as O[k]. During computation no cell reads a shared buffer. Cells only exchange values with their neighbours.

The caller gives a whole input vector in one cycle. The block delays column c by c cycles itself, so each partial sum meets the matching activation. A new vector may be given on every cycle. Results leave each row in the order the vectors were accepted. Weights are written one cell per cycle while the load signal is high. They go into a shadow copy. A commit marker then travels through the grid together with the first vector slot after loading ends, and moves the shadow copy into each cell's working weight. Vectors still in flight therefore finish with the weights they started with.

Top module: `ws_array`

## Requirements
- R1: While reset is held and after it is released, out_valid is all zero. Every working weight resets to zero, so a vector sent before any load gives a sum of 0 on every row.
- R2: For an accepted vector, row k outputs the sum over c of W[k][c] * I[c] as a 40-bit two's-complement value. Weights and activations are signed 16-bit. Column c is in_vec bits [16c+15:16c].
- R3: A vector is accepted on a rising edge where in_valid is 1 and wt_load is 0. For row k, out_valid and the result become visible COLS-1+k edges after that accepting edge, and out_valid is high for exactly one cycle per accepted vector.
- R4: Vectors accepted on consecutive cycles each give their own correct result, one per cycle on each row, in acceptance order. Each activation reaches the bottom of its column unchanged.
- R5: While wt_load is 1, in_valid is ignored and no result is produced for that cycle.
- R6: Vectors accepted before a load begins use the old weights, even while they are still in the grid during the load. Vectors accepted from the first cycle with wt_load low onwards use the newly loaded weights. Working weights do not change while a load continues.
- R7: With wt_load high, the edge writes wt_data into the shadow weight of cell (wt_row, wt_col). wt_row is the output channel k and wt_col is the input channel c. Exactly one cell is written, and none is written with wt_load low.
- R8: Products at the ends of the 16-bit range accumulate without wrap. All weights and inputs at -32768 give 3221225472. Weights at -32768 and inputs at 32767 give -3221127168.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wt_load | input | 1 | Weight load mode; writes one shadow weight per cycle |
| wt_row | input | RW | Row (output channel) of the weight written |
| wt_col | input | CW | Column (input channel) of the weight written |
| wt_data | input | DW | Signed weight value |
| in_valid | input | 1 | Input vector present (ignored while loading) |
| in_vec | input | COLS*DW | Unskewed input vector, column c in slice c |
| out_valid | output | ROWS | Per-row result valid |
| out_sum | output | ROWS*AW | Per-row signed result, row k in slice k |

## Verification
The checker assumes that a new load does not start until the commit marker of the previous load has left the grid. That takes at least ROWS+COLS cycles after wt_load falls. Shadow weights far down the grid would otherwise be overwritten before they are copied. The checker also assumes that wt_row and wt_col stay below ROWS and COLS while loading. The stimulus always keeps at least eight idle or compute cycles between loads, and it only addresses existing cells. Activations and weights sweep the ends of the signed range and zero, and vectors run back to back across the edges of load windows.

// File: rtl/ws_pkg.sv
package ws_pkg;
  // control travelling with an activation slot
  typedef struct packed {
    logic vld;   // slot carries an accepted vector
    logic cmt;   // slot moves shadow weights into working weights
  } tag_t;
endpackage

// File: rtl/ws_skew.sv
module ws_skew
  import ws_pkg::*;
#(
  parameter int COLS = 3,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [COLS*DW-1:0] act_in,
  input  tag_t            tag_in,
  output logic [COLS*DW-1:0] act_out,
  output tag_t            tag_out [COLS]
);
  localparam int SW = DW + 2;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    if (c == 0) begin : g_pass
      assign act_out[DW-1:0] = act_in[DW-1:0];
      assign tag_out[0]      = tag_in;
    end else begin : g_dly
      logic [SW-1:0] pipe [c];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < c; i++) pipe[i] <= '0;
        end else begin
          pipe[0] <= {tag_in, act_in[c*DW +: DW]};
          for (int i = 1; i < c; i++) pipe[i] <= pipe[i-1];
        end
      end
      assign {tag_out[c], act_out[c*DW +: DW]} = pipe[c-1];
    end
  end
endmodule

// File: rtl/ws_pe.sv
module ws_pe
  import ws_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] act_in,
  input  tag_t          tag_in,
  input  logic [AW-1:0] psum_in,
  output logic [DW-1:0] act_out,
  output tag_t          tag_out,
  output logic [AW-1:0] psum_out,
  output logic [DW-1:0] w_active
);
  localparam int PW = 2 * DW;

  // signed multiply, sign-extended product added to the running sum
  function automatic logic [AW-1:0] mac(input logic [AW-1:0] acc,
                                        input logic [DW-1:0] w,
                                        input logic [DW-1:0] a);
    logic signed [PW-1:0] p;
    p = $signed(w) * $signed(a);
    return acc + {{(AW-PW){p[PW-1]}}, p};
  endfunction

  logic [DW-1:0] w_shadow;
  logic [DW-1:0] w_work;
  logic [DW-1:0] w_use;

  assign w_use    = tag_in.cmt ? w_shadow : w_work;
  assign w_active = w_work;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_shadow <= '0;
      w_work   <= '0;
      act_out  <= '0;
      tag_out  <= '0;
      psum_out <= '0;
    end else begin
      if (wr_en)      w_shadow <= wr_data;
      if (tag_in.cmt) w_work   <= w_shadow;
      act_out  <= act_in;
      tag_out  <= tag_in;
      psum_out <= tag_in.vld ? mac(psum_in, w_use, act_in) : psum_in;
    end
  end
endmodule

// File: rtl/ws_array.sv
module ws_array
  import ws_pkg::*;
#(
  parameter int ROWS = 3,
  parameter int COLS = 3,
  parameter int DW   = 16,
  parameter int AW   = 40,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wt_load,
  input  logic [RW-1:0]      wt_row,
  input  logic [CW-1:0]      wt_col,
  input  logic [DW-1:0]      wt_data,
  input  logic               in_valid,
  input  logic [COLS*DW-1:0] in_vec,
  output logic [ROWS-1:0]    out_valid,
  output logic [ROWS*AW-1:0] out_sum
);
  localparam int NPE = ROWS * COLS;

  // named internal events
  logic                 load_q;
  logic                 accept;
  logic                 commit_in;
  logic [NPE-1:0]       shadow_we;
  logic [NPE*DW-1:0]    wt_active_flat;
  logic [COLS*DW-1:0]   bot_act_flat;
  logic [COLS-1:0]      bot_vld;
  logic [COLS-1:0]      bot_cmt;

  tag_t                 top_tag;
  logic [COLS*DW-1:0]   skew_act;
  tag_t                 skew_tag [COLS];

  logic [DW-1:0]        act_v  [ROWS+1][COLS];
  tag_t                 tag_v  [ROWS+1][COLS];
  logic [AW-1:0]        psum_h [ROWS][COLS+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b0;
    else        load_q <= wt_load;
  end

  assign accept    = in_valid & ~wt_load;
  assign commit_in = load_q & ~wt_load;
  assign top_tag   = '{vld: accept, cmt: commit_in};

  ws_skew #(.COLS(COLS), .DW(DW)) u_skew (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_in  (in_vec),
    .tag_in  (top_tag),
    .act_out (skew_act),
    .tag_out (skew_tag)
  );

  for (genvar c = 0; c < COLS; c++) begin : g_top
    assign act_v[0][c] = skew_act[c*DW +: DW];
    assign tag_v[0][c] = skew_tag[c];
    assign bot_act_flat[c*DW +: DW] = act_v[ROWS][c];
    assign bot_vld[c] = tag_v[ROWS][c].vld;
    assign bot_cmt[c] = tag_v[ROWS][c].cmt;
  end

  for (genvar k = 0; k < ROWS; k++) begin : g_row
    assign psum_h[k][0] = '0;
    for (genvar c = 0; c < COLS; c++) begin : g_cell
      assign shadow_we[k*COLS+c] = wt_load && (int'(wt_row) == k) && (int'(wt_col) == c);
      ws_pe #(.DW(DW), .AW(AW)) u_pe (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (shadow_we[k*COLS+c]),
        .wr_data  (wt_data),
        .act_in   (act_v[k][c]),
        .tag_in   (tag_v[k][c]),
        .psum_in  (psum_h[k][c]),
        .act_out  (act_v[k+1][c]),
        .tag_out  (tag_v[k+1][c]),
        .psum_out (psum_h[k][c+1]),
        .w_active (wt_active_flat[(k*COLS+c)*DW +: DW])
      );
    end
    assign out_valid[k]          = tag_v[k+1][COLS-1].vld;
    assign out_sum[k*AW +: AW]   = psum_h[k][COLS];
  end
endmodule

// File: rtl/ws_array_chk.sv
module ws_array_chk #(
  parameter int ROWS = 3,
  parameter int COLS = 3,
  parameter int DW   = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wt_load,
  input logic                 in_valid,
  input logic [COLS*DW-1:0]   in_vec,
  input logic [ROWS*COLS-1:0] shadow_we,
  input logic [ROWS*COLS*DW-1:0] wt_active_flat,
  input logic [ROWS-1:0]      out_valid,
  input logic [COLS*DW-1:0]   bot_act_flat,
  input logic [COLS-1:0]      bot_vld,
  input logic [COLS-1:0]      bot_cmt
);
  localparam int D = ROWS + COLS - 1;

  // port-level model of slot travel
  logic               ld_m;
  logic [D-1:0]       vpipe;
  logic [D-1:0]       cpipe;
  logic [COLS*DW-1:0] dpipe [D];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_m  <= 1'b0;
      vpipe <= '0;
      cpipe <= '0;
      for (int i = 0; i < D; i++) dpipe[i] <= '0;
    end else begin
      ld_m     <= wt_load;
      vpipe[0] <= in_valid && !wt_load;
      cpipe[0] <= ld_m && !wt_load;
      dpipe[0] <= in_vec;
      for (int i = 1; i < D; i++) begin
        vpipe[i] <= vpipe[i-1];
        cpipe[i] <= cpipe[i-1];
        dpipe[i] <= dpipe[i-1];
      end
    end
  end

  // R1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_quiet_chk: assert (out_valid == '0);
    end
  end

  for (genvar k = 0; k < ROWS; k++) begin : g_rowchk
    // R3 R5
    row_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[k] == vpipe[COLS-1+k]);
  end

  for (genvar c = 0; c < COLS; c++) begin : g_colchk
    // R6
    commit_wave_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bot_vld[c] == vpipe[ROWS-1+c]) && (bot_cmt[c] == cpipe[ROWS-1+c]));
    // R4
    act_reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bot_act_flat[c*DW +: DW] == dpipe[ROWS-1+c][c*DW +: DW]);
  end

  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_load && $past(wt_load)) |-> $stable(wt_active_flat));

  // R7
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wt_load |-> $countones(shadow_we) == 1);

  // R7
  idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wt_load |-> shadow_we == '0);
endmodule

bind ws_array ws_array_chk #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wt_load        (wt_load),
  .in_valid       (in_valid),
  .in_vec         (in_vec),
  .shadow_we      (shadow_we),
  .wt_active_flat (wt_active_flat),
  .out_valid      (out_valid),
  .bot_act_flat   (bot_act_flat),
  .bot_vld        (bot_vld),
  .bot_cmt        (bot_cmt)
);

// File: tb/ws_array_tb.sv
module ws_array_tb;
  localparam int ROWS   = 3;
  localparam int COLS   = 3;
  localparam int DW     = 16;
  localparam int AW     = 40;
  localparam int RW     = 2;
  localparam int CW     = 2;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 2048;
  localparam int WDOG   = 20000;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               wt_load;
  logic [RW-1:0]      wt_row;
  logic [CW-1:0]      wt_col;
  logic [DW-1:0]      wt_data;
  logic               in_valid;
  logic [COLS*DW-1:0] in_vec;
  logic [ROWS-1:0]    out_valid;
  logic [ROWS*AW-1:0] out_sum;

  ws_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wt_load(wt_load), .wt_row(wt_row),
    .wt_col(wt_col), .wt_data(wt_data), .in_valid(in_valid),
    .in_vec(in_vec), .out_valid(out_valid), .out_sum(out_sum)
  );

  always #(CLK_NS/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  bit    ek [ROWS][DEPTH];
  bit    ev [ROWS][DEPTH];
  logic [AW-1:0] es [ROWS][DEPTH];
  string et [ROWS][DEPTH];
  int    w_cur [ROWS][COLS];
  int    w_sh  [ROWS][COLS];
  int    a_drv [COLS];
  bit    was_load = 0;
  int    vals [6] = '{-32768, -1, 0, 1, 7, 32767};

  // one slot: drive inputs and record the expected result of every row
  task automatic step(input bit v, input bit ld, input int lr, input int lc,
                      input int wd, input string tag);
    longint s;
    int idx;
    @(negedge clk);
    wt_load  = ld;
    wt_row   = lr[RW-1:0];
    wt_col   = lc[CW-1:0];
    wt_data  = wd[DW-1:0];
    in_valid = v;
    for (int c = 0; c < COLS; c++) in_vec[c*DW +: DW] = a_drv[c][DW-1:0];
    if (ld) w_sh[lr][lc] = wd;
    else if (was_load) w_cur = w_sh;   // R6: new weights from first non-load slot
    was_load = ld;
    for (int k = 0; k < ROWS; k++) begin
      s = 0;
      for (int c = 0; c < COLS; c++) s += longint'(w_cur[k][c]) * longint'(a_drv[c]);
      idx = cyc + COLS + k;            // R3: visible COLS-1+k edges after acceptance
      if (idx < DEPTH) begin
        ek[k][idx] = 1'b1;
        ev[k][idx] = v && !ld;
        es[k][idx] = s[AW-1:0];
        et[k][idx] = tag;
      end
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 0, 0, tag);
  endtask

  task automatic load_all(input int mode, input string tag);
    int wv;
    for (int k = 0; k < ROWS; k++)
      for (int c = 0; c < COLS; c++) begin
        if (mode == 0)      wv = (k + 1) * 100 - (c + 1) * 37;
        else if (mode == 1) wv = 5 - (k * COLS + c) * 1000;
        else                wv = -32768;
        a_drv = '{c + 9, -k - 3, 77};   // R5: garbage with in_valid high
        step(1'b1, 1'b1, k, c, wv, tag);
      end
  endtask

  task automatic vec(input int a0, input int a1, input int a2, input string tag);
    a_drv = '{a0, a1, a2};
    step(1'b1, 1'b0, 0, 0, 0, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // output checks on the falling edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done && cyc < DEPTH) begin
      for (int k = 0; k < ROWS; k++) begin
        if (ek[k][cyc]) begin
          n_chk++;
          if (out_valid[k] !== ev[k][cyc]) begin
            n_fail++;
            $display("FAIL %s row %0d cycle %0d: out_valid=%0b expected %0b",
                     et[k][cyc], k, cyc, out_valid[k], ev[k][cyc]);
          end else if (ev[k][cyc] && out_sum[k*AW +: AW] !== es[k][cyc]) begin
            n_fail++;
            $display("FAIL %s row %0d cycle %0d: out_sum=%0d expected %0d",
                     et[k][cyc], k, cyc, $signed(out_sum[k*AW +: AW]),
                     $signed(es[k][cyc]));
          end
        end
      end
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual cycle %0d expected below %0d",
               cyc, WDOG);
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < ROWS; k++)
      for (int c = 0; c < COLS; c++) begin
        w_cur[k][c] = 0;
        w_sh[k][c]  = 0;
      end
    rst_n = 1'b0; wt_load = 0; wt_row = 0; wt_col = 0; wt_data = 0;
    in_valid = 0; in_vec = '0; a_drv = '{0, 0, 0};
    repeat (3) @(negedge clk);
    n_chk++;                                   // R1 during reset
    if (out_valid !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: out_valid=%b expected 000", out_valid);
    end
    rst_n = 1'b1;
    idle(2, "R1");
    vec(5, -6, 7, "R1");                       // R1: zero weights give zero
    idle(8, "R1");

    load_all(0, "R5");                         // R5 and R7
    vec(1, 0, 0, "R7");                        // probes column 0 of each row
    vec(0, 1, 0, "R7");
    vec(0, 0, 1, "R7");
    idle(6, "R3");
    vec(3, -4, 5, "R3");                       // R3: isolated vector
    idle(8, "R3");

    for (int i = 0; i < 6; i++)                // R2 R4: back-to-back sweep
      for (int j = 0; j < 6; j++)
        for (int l = 0; l < 6; l++)
          vec(vals[i], vals[j], vals[l], "R2 R4");
    idle(8, "R4");

    for (int i = 0; i < 4; i++) vec(11 + i, -12, 13, "R6");   // in flight during load
    load_all(1, "R6");
    for (int i = 0; i < 4; i++) vec(-i, 21, 300, "R6");       // new weights
    idle(8, "R6");

    load_all(2, "R8");
    vec(-32768, -32768, -32768, "R8");
    vec(32767, 32767, 32767, "R8");
    idle(10, "R8");

    done = 1;
    summary();
    $finish;
  end
endmodule